// File: doc/BRIEF.md
# SPI Byte-Addressed Serial Memory Slave

This block is an SPI slave (mode 0) that fronts a 2048-byte internal byte array, behaving like a serial nonvolatile memory whose writes take effect one byte at a time. A master selects it with an active-low chip select, clocks in a one-byte command, and then sends whatever that command needs: a two-byte address followed by a data burst, or a single status byte. Bursts in either direction run for as long as chip select stays low and the serial clock keeps toggling. There is no page buffer, so a write burst has no length limit. Each received byte goes into the array the moment its last bit is sampled.

The serial pins are treated as slow signals. They are sampled by the block's system clock, and their edges are detected inside the block. A status register holds a write-protect-enable flag, a two-bit protection range and the write-enable latch. The protection range blocks writes to the upper quarter, the upper half or the whole array. A write burst that runs into the protected range freezes its address and drops the rest of its data.

The control state machine has these states: `ST_IDLE` (deselected), `ST_OPCODE`, `ST_ADDR_HI`, `ST_ADDR_LO`, `ST_RD_DATA`, `ST_WR_DATA`, `ST_STAT_OUT`, `ST_STAT_IN` and `ST_SKIP`. Its transitions are:
- Chip select falling: `ST_IDLE` to `ST_OPCODE`.
- Opcode byte: read or write to `ST_ADDR_HI`; read-status to `ST_STAT_OUT`; write-status to `ST_STAT_IN` when the latch is set, otherwise `ST_SKIP`; latch commands and unknown codes to `ST_SKIP`.
- Address bytes: `ST_ADDR_HI` to `ST_ADDR_LO`, then to `ST_RD_DATA` for a read or `ST_WR_DATA` for a write.
- Status byte: `ST_STAT_IN` to `ST_SKIP` once its byte has arrived.
- Chip select high: from any state back to `ST_IDLE`.

Top module: `spi_mem_ctrl`

## Requirements
- R1: Command byte 0x06 sets the write-enable latch, and 0x04 clears it. Any other code outside {0x01, 0x02, 0x03, 0x05} is ignored together with every bit that follows it until chip select rises: the latch is unchanged and `so_oe` stays low.
- R2: A write command (0x02) issued while the write-enable latch is clear leaves every array byte unchanged.
- R3: After 0x03 or 0x02, two address bytes follow, MSB first. Only the low 11 bits select the byte; the top five bits of the first address byte are ignored.
- R4: Read data goes out MSB first. Each bit changes after a falling `sck` edge and is valid at the next rising edge, beginning with the first falling edge after the last address bit. `si` is ignored while read data is shifted out.
- R5: A read burst returns consecutive bytes for as long as chip select stays low, and the address wraps from 0x7FF to 0x000.
- R6: In a write burst, each byte is stored as soon as its eighth bit is sampled, including when chip select rises in the very next cycle. The address advances after each stored byte and wraps from 0x7FF to 0x000. A partial byte cut off by chip select rising is discarded.
- R7: Command 0x05 shifts out the status byte. Bit 7 is write-protect-enable, bits 3:2 are the protection range, bit 1 is the write-enable latch, and bits 6:4 and 0 read as 0.
- R8: Command 0x01 followed by one byte updates only status bits 7, 3 and 2, and only when the latch is set. With the latch clear, the status register is unchanged.
- R9: The protection range bits 3:2 select the protected addresses: 00 protects none, 01 protects 0x600 to 0x7FF, 10 protects 0x400 to 0x7FF, and 11 protects the whole array. A protected byte is never written.
- R10: When a write burst reaches a protected address, the address stops advancing and that byte and every later byte of the command are dropped.
- R11: The write-enable latch clears when chip select rises at the end of a 0x02 or 0x01 command. Other commands leave it as it is.
- R12: `so_oe` is high only while read data or status is being shifted out, and it is low from the second clock after chip select rises.
- R13: After reset, the status register reads 0x00 and `so_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low (mode 0) |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master |
| so_oe | output | 1 | Output enable for `so` (high means driven) |

## Verification
Two functions can land in the same system-clock cycle: the commit of a write byte and the chip-select rise that ends the command. The bench provokes this by raising `cs_n` one clock after the eighth rising `sck` edge, so the byte-complete pulse and the deselect edge meet in the control logic. It then judges the result by reading the byte back, and by checking through read-status that the latch was cleared. A second pairing occurs at the protection boundary, where the protection check and the address advance fall on the same byte. A burst that straddles 0x5FF/0x600 is read back afterwards to show exactly where storage stopped.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_STAT_OUT,
        ST_STAT_IN,
        ST_SKIP
    } mem_state_t;

    localparam logic [7:0] CMD_WRSR = 8'h01;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_READ = 8'h03;
    localparam logic [7:0] CMD_WRDI = 8'h04;
    localparam logic [7:0] CMD_RDSR = 8'h05;
    localparam logic [7:0] CMD_WREN = 8'h06;

endpackage

// File: rtl/spi_mem_shifter.sv
// Serial pin sampling, edge detection, byte assembly and output shifting.
module spi_mem_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          si,
    input  logic          tx_load,
    input  logic [DW-1:0] tx_byte,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte,
    output logic          cs_idle,
    output logic          cs_rise,
    output logic          so
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    logic          sck_q, sck_qq, si_q, cs_q, cs_qq;
    logic [CW-1:0] bit_cnt;
    logic [DW-2:0] rx_sh;
    logic [DW-1:0] tx_sh;
    logic          so_q;
    logic          sck_rise, sck_fall;

    assign sck_rise = sck_q & ~sck_qq & ~cs_q;
    assign sck_fall = ~sck_q & sck_qq & ~cs_q;
    assign cs_idle  = cs_q;
    assign cs_rise  = cs_q & ~cs_qq;
    assign so       = so_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            sck_qq    <= 1'b0;
            si_q      <= 1'b0;
            cs_q      <= 1'b1;
            cs_qq     <= 1'b1;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            sck_q     <= sck;
            sck_qq    <= sck_q;
            si_q      <= si;
            cs_q      <= cs_n;
            cs_qq     <= cs_q;
            byte_done <= 1'b0;
            if (cs_q) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[DW-3:0], si_q};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh, si_q};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            so_q  <= 1'b0;
        end else if (tx_load) begin
            tx_sh <= tx_byte;
        end else if (sck_fall) begin
            so_q  <= tx_sh[DW-1];
            tx_sh <= {tx_sh[DW-2:0], 1'b0};
        end
    end

    // R6: a byte completion is a single-cycle event
    p_byte_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    // R6: a byte can only complete while the device was selected
    p_byte_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !$past(cs_q));

endmodule

// File: rtl/spi_mem_protect.sv
// Decodes the two-bit protection range against a byte address.
module spi_mem_protect #(
    parameter int AW = 11
) (
    input  logic [1:0]    range_sel,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic [1:0] top2;
    assign top2 = addr[AW-1:AW-2];

    always_comb begin
        unique case (range_sel)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (top2 == 2'b11);
            2'b10:   hit = top2[1];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_mem_array.sv
// Byte array: synchronous write port, combinational read port.
module spi_mem_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    // R6: a committed byte has a defined address and value
    p_we_known_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (!$isunknown(waddr) && !$isunknown(wdata)));

endmodule

// File: rtl/spi_mem_ctrl.sv
// SPI serial memory slave: command FSM, address counter, status register.
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_oe
);
    localparam int HW = AW - DW;

    mem_state_t    state_q, state_d;
    logic          byte_done, cs_idle, cs_rise;
    logic [DW-1:0] rx_byte;
    logic          tx_load;
    logic [DW-1:0] tx_byte;
    logic [AW-1:0] addr_q;
    logic [HW-1:0] addr_hi_q;
    logic          cmd_rd_q, cmd_wr_q;
    logic          wel_q, wpen_q;
    logic [1:0]    bp_q;
    logic          prot_hit;
    logic          mem_we;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;
    logic [DW-1:0] status;
    logic          load_status;

    spi_mem_shifter #(.DW(DW)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .si        (si),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .cs_idle   (cs_idle),
        .cs_rise   (cs_rise),
        .so        (so)
    );

    spi_mem_protect #(.AW(AW)) protect_i (
        .range_sel (bp_q),
        .addr      (addr_q),
        .hit       (prot_hit)
    );

    spi_mem_array #(.AW(AW), .DW(DW)) array_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (addr_q),
        .wdata (rx_byte),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign status = {wpen_q, 3'b000, bp_q, wel_q, 1'b0};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_idle) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_OPCODE;
                ST_OPCODE: if (byte_done) begin
                    if (rx_byte == CMD_READ || rx_byte == CMD_WRITE)
                        state_d = ST_ADDR_HI;
                    else if (rx_byte == CMD_RDSR)
                        state_d = ST_STAT_OUT;
                    else if (rx_byte == CMD_WRSR && wel_q)
                        state_d = ST_STAT_IN;
                    else
                        state_d = ST_SKIP;
                end
                ST_ADDR_HI: if (byte_done) state_d = ST_ADDR_LO;
                ST_ADDR_LO: if (byte_done)
                    state_d = cmd_rd_q ? ST_RD_DATA : ST_WR_DATA;
                ST_STAT_IN: if (byte_done) state_d = ST_SKIP;
                ST_RD_DATA, ST_WR_DATA, ST_STAT_OUT, ST_SKIP: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // datapath strobes
    always_comb begin
        load_status = byte_done &&
                      ((state_q == ST_OPCODE && rx_byte == CMD_RDSR) ||
                       state_q == ST_STAT_OUT);
        tx_load     = load_status ||
                      (byte_done && ((state_q == ST_ADDR_LO && cmd_rd_q) ||
                                     state_q == ST_RD_DATA));
        raddr       = (state_q == ST_ADDR_LO) ? {addr_hi_q, rx_byte}
                                              : addr_q + 1'b1;
        tx_byte     = load_status ? status : rdata;
        mem_we      = byte_done && (state_q == ST_WR_DATA) && wel_q && !prot_hit;
        so_oe       = (state_q == ST_RD_DATA) || (state_q == ST_STAT_OUT);
    end

    // registered outputs: address counter, command flags, status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            addr_hi_q <= '0;
            cmd_rd_q  <= 1'b0;
            cmd_wr_q  <= 1'b0;
            wel_q     <= 1'b0;
            wpen_q    <= 1'b0;
            bp_q      <= 2'b00;
        end else begin
            if (byte_done) begin
                unique case (state_q)
                    ST_OPCODE: begin
                        cmd_rd_q <= (rx_byte == CMD_READ);
                        cmd_wr_q <= (rx_byte == CMD_WRITE) || (rx_byte == CMD_WRSR);
                        if (rx_byte == CMD_WREN) wel_q <= 1'b1;
                        if (rx_byte == CMD_WRDI) wel_q <= 1'b0;
                    end
                    ST_ADDR_HI: addr_hi_q <= rx_byte[HW-1:0];
                    ST_ADDR_LO: addr_q    <= {addr_hi_q, rx_byte};
                    ST_RD_DATA: addr_q    <= addr_q + 1'b1;
                    ST_WR_DATA: if (wel_q && !prot_hit) addr_q <= addr_q + 1'b1;
                    ST_STAT_IN: begin
                        wpen_q <= rx_byte[7];
                        bp_q   <= rx_byte[3:2];
                    end
                    default: ;
                endcase
            end
            if (cs_rise) begin
                if (cmd_wr_q) wel_q <= 1'b0;
                cmd_wr_q <= 1'b0;
                cmd_rd_q <= 1'b0;
            end
        end
    end

    // R2: nothing reaches the array without the write-enable latch
    p_we_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel_q);

    // R9: the protection decoder never lets a write through
    p_we_unprotected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !prot_hit);

    // R10: a burst that hits the protected range freezes its address
    p_freeze_on_prot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_DATA && byte_done && prot_hit) |=> $stable(addr_q));

    // R5: read bursts step the address by one, modulo the array size
    p_rd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_DATA && byte_done) |=> (addr_q == AW'($past(addr_q) + 1'b1)));

    // R11: deselect after a write-type command drops the latch
    p_wel_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && cmd_wr_q) |=> !wel_q);

    // R12: the output driver is released right after deselect
    p_oe_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !so_oe);

endmodule

// File: tb/spi_mem_ctrl_tb_top.sv
module spi_mem_ctrl_tb_top;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so, so_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    logic [7:0] st, dummy;
    logic       oe_seen;

    // {address as sent (16 bits), data}
    localparam logic [23:0] VEC [6] = '{
        24'hF800_C3, 24'hFFFF_7E, 24'h0400_81,
        24'h5123_4D, 24'h02AA_55, 24'h0010_11
    };

    always #4 clk = ~clk;

    spi_mem_ctrl dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sck   (sck),
        .si    (si),
        .so    (so),
        .so_oe (so_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, input bit early_cs,
                        output logic [7:0] rx, output logic seen);
        rx = '0;
        seen = 1'b0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            si = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = so;
            if (so_oe) seen = 1'b1;
            sck = 1'b1;
            if (early_cs && i == 0) begin
                @(negedge clk);
                cs_n = 1'b1;
            end
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        logic s;
        xfer(b, 8, 1'b0, r, s);
    endtask

    task automatic cs_on();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_on(); send(op); cs_off();
    endtask

    task automatic rdsr(output logic [7:0] s, output logic seen);
        cs_on(); send(8'h05); xfer(8'h00, 8, 1'b0, s, seen); cs_off();
    endtask

    task automatic wr_burst(input logic [15:0] a, input int n);
        cmd1(8'h06);
        cs_on(); send(8'h02); send(a[15:8]); send(a[7:0]);
        for (int k = 0; k < n; k++) send(wbuf[k]);
        cs_off();
    endtask

    task automatic rd_burst(input logic [15:0] a, input int n);
        logic s;
        cs_on(); send(8'h03); send(a[15:8]); send(a[7:0]);
        for (int k = 0; k < n; k++) xfer(8'h00, 8, 1'b0, rbuf[k], s);
        cs_off();
    endtask

    task automatic wrsr(input logic [7:0] v);
        cs_on(); send(8'h01); send(v); cs_off();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R13: reset state
        check("R13 oe after reset", {7'd0, so_oe}, 8'h00);
        rdsr(st, oe_seen);
        check("R13 status after reset", st, 8'h00);
        check("R12 oe during status", {7'd0, oe_seen}, 8'h01);

        // R3: table of single-byte writes, read back with other upper address bits
        for (int v = 0; v < 6; v++) begin
            wbuf[0] = VEC[v][7:0];
            wr_burst(VEC[v][23:8], 1);
        end
        for (int v = 0; v < 6; v++) begin
            rd_burst(VEC[v][23:8] ^ 16'hF800, 1);
            check("R3 table readback", rbuf[0], VEC[v][7:0]);
        end

        // R2: write without the latch changes nothing
        cs_on(); send(8'h02); send(8'h00); send(8'h10); send(8'h77); cs_off();
        rd_burst(16'h0010, 1);
        check("R2 write without latch", rbuf[0], 8'h11);

        // R1 / R11: latch set, survives a read, then cleared
        cmd1(8'h06);
        rdsr(st, oe_seen);
        check("R1 latch set", st, 8'h02);
        rd_burst(16'h0000, 1);
        check("R4 read data", rbuf[0], 8'hC3);
        rdsr(st, oe_seen);
        check("R11 latch kept over read", st, 8'h02);

        // R4: si ignored during read data (sends the latch-clear code)
        cs_on(); send(8'h03); send(8'h04); send(8'h00);
        xfer(8'h04, 8, 1'b0, dummy, oe_seen);
        cs_off();
        check("R4 read with si activity", dummy, 8'h81);
        rdsr(st, oe_seen);
        check("R4 si ignored in read", st, 8'h02);
        cmd1(8'h04);
        rdsr(st, oe_seen);
        check("R1 latch cleared", st, 8'h00);

        // R1: unknown opcode swallows the rest of the command
        cs_on(); send(8'hAB); xfer(8'h06, 8, 1'b0, dummy, oe_seen); cs_off();
        check("R1 unknown opcode oe", {7'd0, oe_seen}, 8'h00);
        rdsr(st, oe_seen);
        check("R1 unknown opcode latch", st, 8'h00);

        // R5 / R6: wrapping burst write and read
        wbuf[0] = 8'hA0; wbuf[1] = 8'hA1; wbuf[2] = 8'hA2; wbuf[3] = 8'hA3;
        wr_burst(16'h07FE, 4);
        rd_burst(16'h07FE, 4);
        for (int k = 0; k < 4; k++) check("R5 R6 wrap burst", rbuf[k], 8'hA0 + 8'(k));

        // R6: partial byte discarded
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
        wr_burst(16'h0020, 2);
        cmd1(8'h06);
        cs_on(); send(8'h02); send(8'h00); send(8'h20); send(8'h5A);
        xfer(8'hFF, 4, 1'b0, dummy, oe_seen);
        cs_off();
        rd_burst(16'h0020, 2);
        check("R6 full byte stored", rbuf[0], 8'h5A);
        check("R6 partial byte dropped", rbuf[1], 8'hC2);
        rdsr(st, oe_seen);
        check("R11 latch cleared after write", st, 8'h00);

        // R6: commit and deselect in the same cycle
        cmd1(8'h06);
        cs_on(); send(8'h02); send(8'h00); send(8'h50);
        xfer(8'h6B, 8, 1'b1, dummy, oe_seen);
        repeat (2 * HALF) @(negedge clk);
        rd_burst(16'h0050, 1);
        check("R6 commit at deselect", rbuf[0], 8'h6B);
        rdsr(st, oe_seen);
        check("R11 latch cleared at deselect", st, 8'h00);

        // R8: status write without the latch is ignored
        wrsr(8'hFF);
        rdsr(st, oe_seen);
        check("R8 status write without latch", st, 8'h00);

        // R9 / R10: prefill then burst into the upper quarter
        for (int k = 0; k < 5; k++) wbuf[k] = 8'h10 + 8'(k);
        wr_burst(16'h05FE, 5);
        cmd1(8'h06);
        wrsr(8'h77);
        rdsr(st, oe_seen);
        check("R8 only bits 7,3,2 written", st, 8'h04);
        for (int k = 0; k < 5; k++) wbuf[k] = 8'hE0 + 8'(k);
        wr_burst(16'h05FE, 5);
        rd_burst(16'h05FE, 5);
        check("R10 before boundary", rbuf[0], 8'hE0);
        check("R10 last unprotected", rbuf[1], 8'hE1);
        check("R10 first protected", rbuf[2], 8'h12);
        check("R10 later protected", rbuf[3], 8'h13);
        check("R10 no advance past stop", rbuf[4], 8'h14);

        // R9 / R7: upper half protected, protect-enable flag
        cmd1(8'h06);
        wrsr(8'h88);
        rdsr(st, oe_seen);
        check("R7 status fields", st, 8'h88);
        wbuf[0] = 8'h3C;
        wr_burst(16'h03FF, 1);
        rd_burst(16'h03FF, 1);
        check("R9 below half writable", rbuf[0], 8'h3C);
        wbuf[0] = 8'h99;
        wr_burst(16'h0400, 1);
        rd_burst(16'h0400, 1);
        check("R9 upper half protected", rbuf[0], 8'h81);

        // R9: whole array protected
        cmd1(8'h06);
        wrsr(8'h0C);
        wbuf[0] = 8'h55;
        wr_burst(16'h0000, 1);
        rd_burst(16'h0000, 1);
        check("R9 whole array protected", rbuf[0], 8'hA2);

        // R12: driver released while deselected
        check("R12 oe idle", {7'd0, so_oe}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule